// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Unit

This block holds two independent multiply-accumulate lanes that run side by side. Each clock, a lane can take one pair of 16-bit operands and form their product. It then loads that product into its own 40-bit accumulator, adds it to the accumulator, subtracts it from the accumulator, or leaves the accumulator as it is. The 40-bit accumulator has eight guard bits above a 32-bit result. This lets long sums grow past the 32-bit range without loss. If the sum leaves the 40-bit range, the lane either clamps it or wraps it, and a sticky flag records the event.

One set of mode bits applies to both lanes for each operation. The mode bits choose signed or unsigned operands, fractional scaling, saturation of the accumulator, and rounding of the 16-bit result. Each lane has three registered outputs: the whole accumulator, a 32-bit result saturated from it, and a 16-bit result rounded and saturated from it. All outputs update on the clock edge that takes the operation. A hold operation re-reads the accumulator under new result settings and does not change it.

Top module: `dmac_dual`

## Requirements
- R1: An operation taken while `in_valid` is 1 appears on every output one clock later, and `out_valid` is 1 for that cycle. While `in_valid` is 0, the accumulators and overflow flags do not change and `out_valid` is 0.
- R2: Lane k reads its operation from `in_op[2k+1:2k]` and its operands from bits [16k+15:16k] of `in_a` and `in_b`. The operation codes are 00 hold, 01 load product, 10 add product, 11 subtract product. The two lanes are independent of each other.
- R3: When `in_signed` is 1, the operands are two's complement values. When it is 0, they are unsigned values and the product is zero-extended.
- R4: When `in_frac` and `in_signed` are both 1, the product is doubled. 0x8000 times 0x8000 then gives 0x7FFF_FFFF. `in_frac` has no effect on unsigned operands.
- R5: The accumulator is a 40-bit two's complement value. An add or subtract whose result leaves that range clamps to 0x7F_FFFF_FFFF or 0x80_0000_0000 when `in_sat` is 1, and wraps modulo 2^40 when `in_sat` is 0.
- R6: A lane's overflow flag is set by any add or subtract that leaves the 40-bit range, whether or not saturation is on. It stays set until reset or until a load operation on that lane.
- R7: The 32-bit result is accumulator bits [31:0] when bits [39:31] are all equal. Otherwise it is 0x7FFF_FFFF for a positive accumulator and 0x8000_0000 for a negative one.
- R8: The 16-bit result is formed as follows. When `in_round` is 1, 0x8000 is first added at full width. The value is then taken as bits [31:16] if it fits in 32 signed bits, and saturates to 0x7FFF or 0x8000 if it does not.
- R9: After a synchronous reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Two-bit operation code per lane |
| in_a | input | 32 | First 16-bit operand per lane |
| in_b | input | 32 | Second 16-bit operand per lane |
| in_signed | input | 1 | Operands are two's complement |
| in_frac | input | 1 | Fractional scaling of signed products |
| in_sat | input | 1 | Clamp the accumulator on overflow |
| in_round | input | 1 | Round the 16-bit result |
| out_valid | output | 1 | Outputs reflect an operation taken last cycle |
| out_acc | output | 80 | 40-bit accumulator per lane |
| out_res32 | output | 64 | Saturated 32-bit result per lane |
| out_res16 | output | 32 | Rounded and saturated 16-bit result per lane |
| out_ovf | output | 2 | Sticky overflow flag per lane |

## Verification
The hardest case to reach is overflow of the 40-bit accumulator itself. Even the largest product is only about 2^32, so at least 128 of them must be summed in a row before the guard bits run out. The stimulus drives long runs of 0xFFFF by 0xFFFF unsigned products, with one lane adding and the other subtracting, so both lanes cross the range limits from opposite sides. It does this once with saturation on and once with it off, and then checks that the sticky flags survive further adds and clear on a load.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    MAC_HOLD = 2'b00,
    MAC_LOAD = 2'b01,
    MAC_ADD  = 2'b10,
    MAC_SUB  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/dmac_mult.sv
// Operand multiplier: one 17x17 signed array covers both operand formats.
module dmac_mult #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             sgn_i,
  input  logic             frac_i,
  output logic [ACC_W-1:0] prod_o
);
  localparam int EXT_W = OP_W + 1;
  localparam int PRD_W = 2 * EXT_W;
  localparam logic [OP_W-1:0] NEG_ONE = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [PRD_W-1:0] FRAC_MAX =
    {{(PRD_W-2*OP_W+1){1'b0}}, {(2*OP_W-1){1'b1}}};

  logic signed [EXT_W-1:0] ax, bx;
  logic signed [PRD_W-1:0] raw;
  logic        [PRD_W-1:0] scaled;

  always_comb begin
    ax  = $signed({sgn_i & a_i[OP_W-1], a_i});
    bx  = $signed({sgn_i & b_i[OP_W-1], b_i});
    raw = ax * bx;
    if (sgn_i && frac_i) begin
      if (a_i == NEG_ONE && b_i == NEG_ONE) scaled = FRAC_MAX;
      else                                  scaled = raw <<< 1;
    end else begin
      scaled = raw;
    end
    prod_o = {{(ACC_W-PRD_W){scaled[PRD_W-1]}}, scaled};
  end
endmodule

// File: rtl/dmac_accum.sv
// Accumulate stage: one extra sum bit exposes overflow of the 40-bit range.
module dmac_accum
  import dmac_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] prod_i,
  input  mac_op_e          op_i,
  input  logic             sat_i,
  output logic [ACC_W-1:0] nxt_o,
  output logic             hit_o
);
  localparam int SUM_W = ACC_W + 1;
  localparam logic [ACC_W-1:0] MOST_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MOST_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic [SUM_W-1:0] ea, ep, sum;

  always_comb begin
    ea = {acc_i[ACC_W-1], acc_i};
    ep = {prod_i[ACC_W-1], prod_i};
    case (op_i)
      MAC_LOAD: sum = ep;
      MAC_ADD:  sum = ea + ep;
      MAC_SUB:  sum = ea - ep;
      default:  sum = ea;
    endcase
    hit_o = (op_i == MAC_ADD || op_i == MAC_SUB) &&
            (sum[ACC_W] != sum[ACC_W-1]);
    if (hit_o && sat_i) nxt_o = sum[ACC_W] ? MOST_NEG : MOST_POS;
    else                nxt_o = sum[ACC_W-1:0];
  end
endmodule

// File: rtl/dmac_extract.sv
// Result extraction: saturated 32-bit word and rounded, saturated 16-bit half.
module dmac_extract #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              rnd_i,
  output logic [2*OP_W-1:0] r32_o,
  output logic [OP_W-1:0]   r16_o
);
  localparam int RES_W = 2 * OP_W;
  localparam int EXT_W = ACC_W + 1;
  localparam logic [EXT_W-1:0] HALF =
    {{(EXT_W-OP_W){1'b0}}, 1'b1, {(OP_W-1){1'b0}}};

  logic [ACC_W-RES_W:0] top32;
  logic [EXT_W-RES_W:0] top16;
  logic [EXT_W-1:0]     rv;

  always_comb begin
    top32 = acc_i[ACC_W-1:RES_W-1];
    if ((&top32) || !(|top32)) r32_o = acc_i[RES_W-1:0];
    else if (acc_i[ACC_W-1])   r32_o = {1'b1, {(RES_W-1){1'b0}}};
    else                       r32_o = {1'b0, {(RES_W-1){1'b1}}};

    rv    = {acc_i[ACC_W-1], acc_i} + (rnd_i ? HALF : '0);
    top16 = rv[EXT_W-1:RES_W-1];
    if ((&top16) || !(|top16)) r16_o = rv[RES_W-1:OP_W];
    else if (rv[EXT_W-1])      r16_o = {1'b1, {(OP_W-1){1'b0}}};
    else                       r16_o = {1'b0, {(OP_W-1){1'b1}}};
  end
endmodule

// File: rtl/dmac_lane.sv
// One MAC lane: multiplier, accumulator and result registers.
module dmac_lane
  import dmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  mac_op_e           op_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  input  logic              sgn_i,
  input  logic              frac_i,
  input  logic              sat_i,
  input  logic              rnd_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              ovf_o,
  output logic [2*OP_W-1:0] r32_o,
  output logic [OP_W-1:0]   r16_o
);
  localparam int RES_W = 2 * OP_W;
  localparam logic [ACC_W-1:0] FRAC_FLOOR =
    {{(ACC_W-RES_W+1){1'b1}}, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] R32_POS = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] R32_NEG = {1'b1, {(RES_W-1){1'b0}}};

  logic [ACC_W-1:0] prod, nxt;
  logic             hit;
  logic [RES_W-1:0] r32_n;
  logic [OP_W-1:0]  r16_n;

  dmac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .a_i(a_i), .b_i(b_i), .sgn_i(sgn_i), .frac_i(frac_i), .prod_o(prod)
  );

  dmac_accum #(.ACC_W(ACC_W)) u_accum (
    .acc_i(acc_o), .prod_i(prod), .op_i(op_i), .sat_i(sat_i),
    .nxt_o(nxt), .hit_o(hit)
  );

  dmac_extract #(.OP_W(OP_W), .ACC_W(ACC_W)) u_extract (
    .acc_i(nxt), .rnd_i(rnd_i), .r32_o(r32_n), .r16_o(r16_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
      r32_o <= '0;
      r16_o <= '0;
    end else if (valid_i) begin
      acc_o <= nxt;
      ovf_o <= (op_i == MAC_LOAD) ? 1'b0 : (ovf_o | hit);
      r32_o <= r32_n;
      r16_o <= r16_n;
    end
  end

  p_idle_stable_r1: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(acc_o) && $stable(ovf_o));

  p_hold_keeps_r2: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == MAC_HOLD) |=> $stable(acc_o) && $stable(ovf_o));

  p_frac_no_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && sgn_i && frac_i) |-> prod != FRAC_FLOOR);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !(valid_i && op_i == MAC_LOAD)) |=> ovf_o);

  p_load_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == MAC_LOAD) |=> !ovf_o);

  p_res32_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    !((&acc_o[ACC_W-1:RES_W-1]) || !(|acc_o[ACC_W-1:RES_W-1]))
      |-> (r32_o == R32_POS || r32_o == R32_NEG));
endmodule

// File: rtl/dmac_dual.sv
// Top: parallel MAC lanes sharing one mode bundle.
module dmac_dual
  import dmac_pkg::*;
#(
  parameter int LANES = 2,
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [2*LANES-1:0]        in_op,
  input  logic [OP_W*LANES-1:0]     in_a,
  input  logic [OP_W*LANES-1:0]     in_b,
  input  logic                      in_signed,
  input  logic                      in_frac,
  input  logic                      in_sat,
  input  logic                      in_round,
  output logic                      out_valid,
  output logic [ACC_W*LANES-1:0]    out_acc,
  output logic [2*OP_W*LANES-1:0]   out_res32,
  output logic [OP_W*LANES-1:0]     out_res16,
  output logic [LANES-1:0]          out_ovf
);
  localparam int RES_W = 2 * OP_W;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dmac_lane #(.OP_W(OP_W), .ACC_W(ACC_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .valid_i(in_valid),
      .op_i   (mac_op_e'(in_op[2*k +: 2])),
      .a_i    (in_a[OP_W*k +: OP_W]),
      .b_i    (in_b[OP_W*k +: OP_W]),
      .sgn_i  (in_signed),
      .frac_i (in_frac),
      .sat_i  (in_sat),
      .rnd_i  (in_round),
      .acc_o  (out_acc[ACC_W*k +: ACC_W]),
      .ovf_o  (out_ovf[k]),
      .r32_o  (out_res32[RES_W*k +: RES_W]),
      .r16_o  (out_res16[OP_W*k +: OP_W])
    );
  end
endmodule

// File: tb/dmac_dual_bench.sv
module dmac_dual_bench;
  localparam int L = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [3:0]    in_op = '0;
  logic [31:0]   in_a = '0, in_b = '0;
  logic          in_signed = 1'b0, in_frac = 1'b0, in_sat = 1'b0, in_round = 1'b0;
  logic          out_valid;
  logic [79:0]   out_acc;
  logic [63:0]   out_res32;
  logic [31:0]   out_res16;
  logic [1:0]    out_ovf;

  always #10 clk = ~clk;

  dmac_dual u_dmac_dual (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_signed(in_signed), .in_frac(in_frac),
    .in_sat(in_sat), .in_round(in_round), .out_valid(out_valid),
    .out_acc(out_acc), .out_res32(out_res32), .out_res16(out_res16),
    .out_ovf(out_ovf)
  );

  typedef struct packed {
    logic [1:0][39:0] acc;
    logic [1:0][31:0] r32;
    logic [1:0][15:0] r16;
    logic [1:0]       ovf;
  } exp_t;

  exp_t   exp_q[$];
  string  tag_q[$];
  longint m_acc[L];
  bit     m_ovf[L];
  logic [39:0] mon_acc[L];
  logic        mon_ovf[L];
  int     total = 0, fails = 0;
  bit     done = 1'b0;

  localparam longint MAXA = 64'sd549755813887;
  localparam longint MINA = -64'sd549755813888;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  function automatic longint f_prod(input logic [15:0] a, input logic [15:0] b,
                                    input bit sg, input bit fr);
    longint p;
    if (sg) begin
      p = longint'($signed(a)) * longint'($signed(b));
      if (fr) begin
        if (a == 16'h8000 && b == 16'h8000) p = 64'h7FFF_FFFF;
        else p = p * 2;
      end
    end else begin
      p = longint'({48'b0, a}) * longint'({48'b0, b});
    end
    return p;
  endfunction

  function automatic longint f_wrap(input longint v);
    logic [63:0] t;
    t = v;
    return longint'({{24{t[39]}}, t[39:0]});
  endfunction

  function automatic logic [31:0] f_r32(input longint v);
    if (v > 64'sd2147483647)       return 32'h7FFF_FFFF;
    else if (v < -64'sd2147483648) return 32'h8000_0000;
    else                           return v[31:0];
  endfunction

  function automatic logic [15:0] f_r16(input longint v, input bit rd);
    longint w;
    w = v + (rd ? 64'sd32768 : 64'sd0);
    if (w > 64'sd2147483647)       return 16'h7FFF;
    else if (w < -64'sd2147483648) return 16'h8000;
    else                           return w[31:16];
  endfunction

  task automatic issue(input logic [1:0] op0, input logic [1:0] op1,
                       input logic [15:0] a0, input logic [15:0] b0,
                       input logic [15:0] a1, input logic [15:0] b1,
                       input bit sg, input bit fr, input bit st, input bit rd,
                       input string tag);
    exp_t e;
    logic [1:0]  ops[L];
    logic [15:0] as[L], bs[L];
    @(negedge clk);
    in_valid = 1'b1; in_op = {op1, op0};
    in_a = {a1, a0}; in_b = {b1, b0};
    in_signed = sg; in_frac = fr; in_sat = st; in_round = rd;
    ops[0] = op0; ops[1] = op1; as[0] = a0; as[1] = a1; bs[0] = b0; bs[1] = b1;
    for (int l = 0; l < L; l++) begin
      longint p, n;
      p = f_prod(as[l], bs[l], sg, fr);
      n = m_acc[l];
      case (ops[l])
        2'b01: begin n = p; m_ovf[l] = 1'b0; end
        2'b10: n = m_acc[l] + p;
        2'b11: n = m_acc[l] - p;
        default: n = m_acc[l];
      endcase
      if ((ops[l] == 2'b10 || ops[l] == 2'b11) && (n > MAXA || n < MINA)) begin
        m_ovf[l] = 1'b1;
        if (st) n = (n > MAXA) ? MAXA : MINA;
        else    n = f_wrap(n);
      end
      m_acc[l] = n;
      e.acc[l] = n[39:0];
      e.r32[l] = f_r32(n);
      e.r16[l] = f_r16(n, rd);
      e.ovf[l] = m_ovf[l];
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_op = {$urandom} [3:0];
    end
  endtask

  // Monitor: pops expected items as results come out, checks stability when idle.
  initial begin
    for (int l = 0; l < L; l++) begin mon_acc[l] = '0; mon_ovf[l] = 1'b0; end
    forever begin
      @(posedge clk);
      #2;
      if (!rst && !done) begin
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            chk("R1", "unexpected out_valid", 64'd1, 64'd0);
          end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            for (int l = 0; l < L; l++) begin
              chk(t, $sformatf("lane%0d acc", l), out_acc[40*l +: 40], e.acc[l]);
              chk(t, $sformatf("lane%0d res32", l), out_res32[32*l +: 32], e.r32[l]);
              chk(t, $sformatf("lane%0d res16", l), out_res16[16*l +: 16], e.r16[l]);
              chk(t, $sformatf("lane%0d ovf", l), out_ovf[l], e.ovf[l]);
              mon_acc[l] = e.acc[l];
              mon_ovf[l] = e.ovf[l];
            end
          end
        end else begin
          for (int l = 0; l < L; l++) begin
            chk("R1", $sformatf("lane%0d idle acc", l), out_acc[40*l +: 40], mon_acc[l]);
            chk("R1", $sformatf("lane%0d idle ovf", l), out_ovf[l], mon_ovf[l]);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < L; l++) begin m_acc[l] = 0; m_ovf[l] = 1'b0; end
    repeat (3) @(posedge clk);
    #2;
    // R9: reset state
    chk("R9", "out_valid", out_valid, 0);
    chk("R9", "out_acc", out_acc, 0);
    chk("R9", "out_res32", out_res32, 0);
    chk("R9", "out_res16", out_res16, 0);
    chk("R9", "out_ovf", out_ovf, 0);
    @(negedge clk);
    rst = 1'b0;

    // R3: signed versus unsigned operands
    issue(2'b01, 2'b01, 16'd3, 16'hFFFC, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, "R3");
    issue(2'b01, 2'b01, 16'd3, 16'hFFFC, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, "R3");
    // R2: add, subtract, hold, lanes independent
    issue(2'b10, 2'b11, 16'd100, 16'd200, 16'd7, 16'd9, 1, 0, 0, 0, "R2");
    issue(2'b11, 2'b10, 16'hFF00, 16'h0123, 16'h8000, 16'h7FFF, 1, 0, 1, 1, "R2");
    issue(2'b00, 2'b10, 16'h1234, 16'h5678, 16'd1, 16'd1, 1, 0, 0, 1, "R2");
    // R4: fractional scaling and its corner, ignored when unsigned
    issue(2'b01, 2'b01, 16'h4000, 16'h4000, 16'h8000, 16'h8000, 1, 1, 0, 0, "R4");
    issue(2'b10, 2'b10, 16'hC000, 16'h4000, 16'h8000, 16'h8000, 1, 1, 1, 0, "R4");
    issue(2'b01, 2'b01, 16'h8000, 16'h8000, 16'hC000, 16'h4000, 0, 1, 0, 0, "R4");
    // R1: idle cycles leave state untouched
    idle(4);

    // R5: saturation, lane0 upward, lane1 downward
    issue(2'b01, 2'b01, 16'd0, 16'd0, 16'd0, 16'd0, 0, 0, 1, 0, "R5");
    for (int i = 0; i < 140; i++)
      issue(2'b10, 2'b11, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, "R5");
    // R6: flags stay set after further adds and idle
    issue(2'b10, 2'b10, 16'd1, 16'd1, 16'd1, 16'd1, 1, 0, 0, 0, "R6");
    idle(2);
    issue(2'b01, 2'b00, 16'd5, 16'd5, 16'd0, 16'd0, 1, 0, 0, 0, "R6");
    // R5: wrap without saturation
    issue(2'b01, 2'b01, 16'd0, 16'd0, 16'd0, 16'd0, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 140; i++)
      issue(2'b10, 2'b11, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, "R5");

    // R7: 32-bit result saturation both ways
    issue(2'b01, 2'b01, 16'd0, 16'd0, 16'd0, 16'd0, 0, 0, 0, 0, "R7");
    issue(2'b10, 2'b11, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, "R7");
    // R8: rounding, truncation, rounding into saturation
    issue(2'b01, 2'b01, 16'h0080, 16'h0100, 16'hFFFF, 16'h8000, 0, 0, 0, 1, "R8");
    issue(2'b00, 2'b00, 16'd0, 16'd0, 16'd0, 16'd0, 0, 0, 0, 0, "R8");
    issue(2'b11, 2'b11, 16'h0080, 16'h0100, 16'hFFFF, 16'h8000, 0, 0, 0, 1, "R8");

    // R2: random mix of operations and modes
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      issue(r[1:0], r[3:2], 16'($urandom), 16'($urandom), 16'($urandom),
            16'($urandom), r[4], r[5], r[6], r[7], "R2");
      if (r[10:8] == 3'd0) idle(1);
    end
    idle(4);
    chk("R1", "pending results", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule